// File: doc/BRIEF.md
# Periodic 0-1-0 Lock Detector

This block watches a serial bit stream, one bit per accepted clock cycle, and raises a single-bit flag once it has received 0, then 1, then 0. The flag then stays high on every later bit that carries on the repeating period 0,1,0,0,1,0,... It drops on the first bit that breaks the period. A plain sequence detector pulses once for each occurrence; this block instead reports that the stream is locked onto the period.

The flag is a Mealy output: it is computed from the present state and the bit being presented now. It therefore rises in the same cycle as the bit that completes the first 0-1-0. A qualifier input marks which cycles carry a bit. On the other cycles both the state and the flag stay frozen. After a break, the search starts again from whatever tail of the received bits can still open a new 0-1-0.

The machine has six named states, held in three binary-coded bits:
- `ST_IDLE`: no usable tail.
- `ST_SAW0`: the tail is 0.
- `ST_SAW01`: the tail is 01.
- `ST_LOCK_A`: locked, just ended a period, and the next bit should be 0.
- `ST_LOCK_B`: locked, and the next bit should be 1.
- `ST_LOCK_C`: locked, and the next bit should be 0.

The transitions, written as state, input bit, next state and flag:
- `ST_IDLE`: 0 goes to `ST_SAW0` with flag 0. 1 stays in `ST_IDLE` with flag 0.
- `ST_SAW0`: 0 stays in `ST_SAW0` with flag 0. 1 goes to `ST_SAW01` with flag 0.
- `ST_SAW01`: 0 goes to `ST_LOCK_A` with flag 1. 1 goes to `ST_IDLE` with flag 0.
- `ST_LOCK_A`: 0 goes to `ST_LOCK_B` with flag 1. 1 goes to `ST_SAW01` with flag 0.
- `ST_LOCK_B`: 1 goes to `ST_LOCK_C` with flag 1. 0 goes to `ST_SAW0` with flag 0.
- `ST_LOCK_C`: 0 goes to `ST_LOCK_A` with flag 1. 1 goes to `ST_IDLE` with flag 0.

Top module: `pattern_lock_fsm`

## Requirements
- R1: A synchronous, active-high `rst` puts the machine in `ST_IDLE` and clears the held flag. Bits received before the reset never count toward a later match.
- R2: `lock_o` goes to 1 in the same cycle as the accepted 0 that completes the first 0-1-0 after a point where the machine was not locked.
- R3: While locked, `lock_o` stays 1 on every accepted bit that equals the next bit of the period 0,1,0 (repeating). For the input 010010010 the flags are 001111111.
- R4: `lock_o` goes to 0 on the first accepted bit that departs from the period. For the input 010000 the flags are 001100.
- R5: After a break, the longest tail that is a prefix of the period is kept. A break by a 1 after a completed period leaves the tail 01, so 01010 gives the flags 00101. A break by a 0 while a 1 is expected leaves the tail 0, so 0100010 gives 0011001.
- R6: In a cycle with `in_valid` = 0, `in_bit` is ignored. The state does not change, and `lock_o` repeats its value from the last accepted bit (0 if no bit has been accepted since reset).
- R7: `lock_o` is 1 only when, counting back from the current accepted bit, the longest run of bits that follows the period 0,1,0 from its start is at least 3 bits long. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial stream bit |
| lock_o | output | 1 | Lock flag, Mealy output of state and current bit |

## Verification
Every 10-bit stream is presented from reset, with some idle cycles inserted. Each flag is compared against the longest tail of the stream that follows the period, computed directly from the bits. The expected value thus separates a first match, continued lock, a break, and a restart from a reused tail. Idle cycles carry the complement of the neighbouring bit, so a design that samples `in_bit` without its qualifier would show a wrong flag. Directed streams cover the two documented waveforms, both kinds of tail reuse, and a reset in the middle of a partial pattern.

// File: rtl/pattern_lock_pkg.sv
package pattern_lock_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_SAW0   = 3'd1,
        ST_SAW01  = 3'd2,
        ST_LOCK_A = 3'd3,
        ST_LOCK_B = 3'd4,
        ST_LOCK_C = 3'd5
    } lock_state_t;

    function automatic logic is_locked(input lock_state_t s);
        return (s == ST_LOCK_A) || (s == ST_LOCK_B) || (s == ST_LOCK_C);
    endfunction

endpackage

// File: rtl/pattern_lock_next.sv
module pattern_lock_next
    import pattern_lock_pkg::*;
(
    input  lock_state_t cur_s,
    input  logic        bit_i,
    output lock_state_t nxt_s
);

    always_comb begin
        nxt_s = ST_IDLE;
        unique case (cur_s)
            ST_IDLE:   nxt_s = bit_i ? ST_IDLE   : ST_SAW0;
            ST_SAW0:   nxt_s = bit_i ? ST_SAW01  : ST_SAW0;
            ST_SAW01:  nxt_s = bit_i ? ST_IDLE   : ST_LOCK_A;
            ST_LOCK_A: nxt_s = bit_i ? ST_SAW01  : ST_LOCK_B;
            ST_LOCK_B: nxt_s = bit_i ? ST_LOCK_C : ST_SAW0;
            ST_LOCK_C: nxt_s = bit_i ? ST_IDLE   : ST_LOCK_A;
            default:   nxt_s = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pattern_lock_out.sv
module pattern_lock_out
    import pattern_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  lock_state_t cur_s,
    input  logic        bit_i,
    output logic        flag_o
);

    logic mealy_flag;
    logic held_q;

    always_comb begin
        mealy_flag = 1'b0;
        unique case (cur_s)
            ST_IDLE:   mealy_flag = 1'b0;
            ST_SAW0:   mealy_flag = 1'b0;
            ST_SAW01:  mealy_flag = ~bit_i;
            ST_LOCK_A: mealy_flag = ~bit_i;
            ST_LOCK_B: mealy_flag = bit_i;
            ST_LOCK_C: mealy_flag = ~bit_i;
            default:   mealy_flag = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (valid_i) begin
            held_q <= mealy_flag;
        end
    end

    assign flag_o = valid_i ? mealy_flag : held_q;

    AST_LOCK_B_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cur_s == ST_LOCK_B && bit_i) |-> flag_o); // R3

    AST_IDLE_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (cur_s == ST_IDLE || cur_s == ST_SAW0)) |-> !flag_o); // R7

endmodule

// File: rtl/pattern_lock_fsm.sv
module pattern_lock_fsm
    import pattern_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic lock_o
);

    lock_state_t state_q;
    lock_state_t state_d;

    pattern_lock_next u_next (
        .cur_s (state_q),
        .bit_i (in_bit),
        .nxt_s (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (in_valid) begin
            state_q <= state_d;
        end
    end

    pattern_lock_out u_out (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .cur_s   (state_q),
        .bit_i   (in_bit),
        .flag_o  (lock_o)
    );

    AST_RESET_TO_IDLE: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE)); // R1

    AST_FIRST_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == ST_SAW01 && !in_bit) |-> (lock_o && state_d == ST_LOCK_A)); // R2

    AST_DROP_LEAVES_LOCK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_locked(state_q) && !lock_o) |=> !is_locked(state_q)); // R4

    AST_REUSE_TAIL_01: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_q == ST_LOCK_A && in_bit) |=> (state_q == ST_SAW01)); // R5

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state_q)); // R6

    AST_FLAG_MEANS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lock_o) |-> is_locked(state_d)); // R7

endmodule

// File: tb/pattern_lock_fsm_test.sv
module pattern_lock_fsm_test;

    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_LEN  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic lock_o;

    int n_checks = 0;
    int n_fails = 0;

    pattern_lock_fsm uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .lock_o   (lock_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tail_len(input logic [15:0] b, input int idx);
        for (int len = idx + 1; len >= 1; len--) begin
            bit ok = 1'b1;
            for (int j = 0; j < len; j++) begin
                if (b[idx - len + 1 + j] != ((j % 3) == 1)) ok = 1'b0;
            end
            if (ok) return len;
        end
        return 0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lock_o actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", lock_o, 1'b0);
    endtask

    task automatic drive(input logic v, input logic b);
        @(negedge clk);
        in_valid = v;
        in_bit = b;
        #1;
    endtask

    task automatic run_stream(input logic [15:0] bits, input int len, input logic [15:0] exp_flags, input string req);
        for (int i = 0; i < len; i++) begin
            drive(1'b1, bits[i]);
            check(req, lock_o, exp_flags[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual run unfinished, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();

        for (int s = 0; s < (1 << SWEEP_LEN); s++) begin
            logic [15:0] bits;
            logic last;
            bits = 16'(s);
            do_reset();
            last = 1'b0;
            for (int i = 0; i < SWEEP_LEN; i++) begin
                logic exp;
                exp = (tail_len(bits, i) >= 3);
                drive(1'b1, bits[i]);
                if (exp && !last)       check("R2", lock_o, exp);
                else if (exp && last)   check("R3", lock_o, exp);
                else if (!exp && last)  check("R4", lock_o, exp);
                else                    check("R7", lock_o, exp);
                last = exp;
                if ((i % 4 == 3) && bits[(i + s) % SWEEP_LEN]) begin
                    drive(1'b0, ~bits[i]);
                    check("R6", lock_o, last);
                end
            end
        end

        // R4 documented break: 010000 -> 001100 (bit 0 first)
        do_reset();
        run_stream(16'b000010, 6, 16'b001100, "R4");

        // R3 long lock: 010010010 -> 001111111
        do_reset();
        run_stream(16'b010010010, 9, 16'b111111100, "R3");

        // R5 break by 1 then relock: 01010 -> 00101
        do_reset();
        run_stream(16'b01010, 5, 16'b10100, "R5");

        // R5 break by 0 then relock: 0100010 -> 0011001
        do_reset();
        run_stream(16'b0100010, 7, 16'b1001100, "R5");

        // R1 reset mid-pattern: 01, reset, 10 must not match
        do_reset();
        run_stream(16'b10, 2, 16'b00, "R1");
        do_reset();
        run_stream(16'b01, 2, 16'b00, "R1");

        // R6 long idle gap inside a lock, with the bit toggled
        do_reset();
        run_stream(16'b010, 3, 16'b100, "R2");
        for (int k = 0; k < 5; k++) begin
            drive(1'b0, k[0]);
            check("R6", lock_o, 1'b1);
        end
        drive(1'b1, 1'b0);
        check("R3", lock_o, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule